// File: doc/BRIEF.md
# ATM Cell Header Error Check and Filter

This block sits on the receive side of an ATM link, after cell boundaries have been found. It takes a byte stream in which every cell is 53 bytes long and its first byte is flagged. The first four bytes of each cell are the header and the fifth is the header check byte. The block checks that byte against the header and acts on the result. A clean cell is forwarded. A cell with one flipped header bit can be repaired. Other errored cells are removed, or swapped for a filler cell when the link feeds an inverse-multiplexing group. Idle and unassigned cells can also be filtered out. A small two-state machine tracks recent errors: repair is tried only while the link has been clean, and the first error moves the machine into a stricter detect-only state.

Every byte is forwarded through a fixed six-cycle pipeline, so the output keeps the input's spacing. Removed cells leave a gap of the same length. A saturating counter holds the number of errored cells that were not repaired.

Top module: `hec_filter`

## Requirements
- R1: An input cell is CELL_LEN (default 53) bytes on consecutive `in_valid` cycles, with `in_sop` high on byte 0. Every forwarded byte appears on the outputs exactly 6 clock cycles after it was presented, with `out_sop` marking byte 0.
- R2: The check byte (byte 4) is the CRC-8 of header bytes 0..3 with generator x^8+x^2+x+1, MSB first, zero initial value, XORed with 0x55. A cell whose check byte matches is forwarded with all 53 bytes unchanged.
- R3: In the correction state with `corr_en`=1, a cell with exactly one flipped bit anywhere in its 40 header-plus-check bits is forwarded with that bit restored. This includes a flip inside the check byte.
- R4: A cell whose syndrome matches no single-bit pattern is treated as a multi-bit error and is never forwarded as received.
- R5: After reset the machine is in the correction state (`in_detect`=0). Any errored cell, repaired or not, moves it to the detection state (`in_detect`=1). The next cell with a matching check byte moves it back to correction.
- R6: A single-bit error cell is discarded, not repaired, when it arrives in the detection state or when `corr_en`=0.
- R7: `bad_cnt` increments once for every discarded errored cell and saturates at all ones. It does not change for a repaired cell or a clean cell.
- R8: With `ima_mode`=0 a discarded errored cell produces no output bytes. With `ima_mode`=1 it is replaced, in its own slot, by a filler cell: bytes 00 00 00 01 52, followed by 48 bytes of 0x6A.
- R9: With `drop_idle_en`=1, error-free cells are removed in both modes when they are idle or unassigned. Idle means header 00 00 00 01. Unassigned means VPI and VCI all zero (header bits 27..4 of the 32-bit header) with CLP (bit 0) clear. With `drop_idle_en`=0 such cells pass.
- R10: During and right after reset, `out_valid`=0, `bad_cnt`=0 and `in_detect`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is byte 0 of a cell |
| in_data | input | 8 | Input byte |
| corr_en | input | 1 | Enables single-bit header repair |
| ima_mode | input | 1 | 1: replace discarded cells with filler; 0: remove them |
| drop_idle_en | input | 1 | Removes idle and unassigned cells |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is byte 0 of a cell |
| out_data | output | 8 | Output byte |
| bad_cnt | output | CNT_W | Saturating count of discarded errored cells |
| in_detect | output | 1 | 1 while the machine is in the detection state |

## Verification
The embedded properties watch the state machine and counter on every cycle. Any nonzero syndrome must land in detection and a zero syndrome in correction. A repair must leave the counter still and a discard must step it. The syndrome match must name at most one bit, and the input must keep each cell contiguous. Only the bench scenarios can show the byte-exact results of the policies: the restored header after a repair, the filler cell in its slot, the gaps left by removed cells, idle and unassigned filtering, counter saturation and the six-cycle latency. The bench compares these against a scoreboard filled by its own model.

// File: rtl/hec_filter_pkg.sv
package hec_filter_pkg;

  localparam int HDR_BYTES = 5;
  localparam int HDR_BITS  = 8 * HDR_BYTES;
  localparam logic [7:0] COSET     = 8'h55;
  localparam logic [7:0] IDLE_FILL = 8'h6A;

  typedef enum logic [1:0] {DISP_PASS, DISP_DROP, DISP_FILL} disp_e;
  typedef enum logic {ST_CORR, ST_DET} hec_st_e;

  // CRC-8, generator x^8+x^2+x+1, MSB first, zero start
  function automatic logic [7:0] crc8_32(input logic [31:0] v);
    logic [7:0] c;
    c = '0;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ v[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // syndrome produced by a lone flip at bit p of {header, check byte}
  function automatic logic [7:0] unit_syn(input int p);
    logic [31:0] u;
    if (p < 8) return 8'h01 << p;
    u = '0;
    u[p-8] = 1'b1;
    return crc8_32(u);
  endfunction

endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import hec_filter_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr,
  output logic                clean,
  output logic                single,
  output logic [HDR_BITS-1:0] flip
);

  logic [7:0] syn;
  assign syn = crc8_32(hdr[HDR_BITS-1:8]) ^ COSET ^ hdr[7:0];

  // one comparator per header bit position against its fixed syndrome
  for (genvar p = 0; p < HDR_BITS; p++) begin : g_pos
    localparam logic [7:0] SYN_P = unit_syn(p);
    assign flip[p] = (syn == SYN_P);
  end

  assign clean  = (syn == 8'h00);
  assign single = |flip;

endmodule

// File: rtl/hec_ctrl.sv
module hec_ctrl
  import hec_filter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_stb,
  input  logic             clean,
  input  logic             single,
  input  logic             corr_en,
  output logic             fix,
  output logic             bad,
  output logic             detect,
  output logic [CNT_W-1:0] bad_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  hec_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d = st_q;
    fix  = 1'b0;
    bad  = 1'b0;
    if (dec_stb) begin
      if (clean) begin
        st_d = ST_CORR;
      end else begin
        st_d = ST_DET;
        if (single && corr_en && (st_q == ST_CORR)) fix = 1'b1;
        else                                        bad = 1'b1;
      end
    end
  end

  assign cnt_en = bad && (cnt_q != CNT_MAX);
  assign cnt_d  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CORR;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign detect  = (st_q == ST_DET);
  assign bad_cnt = cnt_q;

  a_r5_err_to_det: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && !clean) |=> detect);
  a_r5_good_to_corr: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && clean) |=> !detect);
  a_r7_fix_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && single && corr_en && !detect) |=> $stable(bad_cnt));
  a_r7_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && !clean && !(single && corr_en && !detect) && bad_cnt != CNT_MAX)
    |=> bad_cnt == $past(bad_cnt) + 1'b1);

endmodule

// File: rtl/hec_filter.sv
module hec_filter
  import hec_filter_pkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic             corr_en,
  input  logic             ima_mode,
  input  logic             drop_idle_en,
  output logic             out_valid,
  output logic             out_sop,
  output logic [7:0]       out_data,
  output logic [CNT_W-1:0] bad_cnt,
  output logic             in_detect
);

  localparam int DLY   = HDR_BYTES;
  localparam int IDX_W = $clog2(CELL_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(CELL_LEN);
  localparam logic [IDX_W-1:0] IDX_HEC = IDX_W'(HDR_BYTES - 1);
  localparam logic [HDR_BITS-1:0] FILL_HDR = {32'h0000_0001, crc8_32(32'h0000_0001) ^ COSET};

  // ---------------- input byte position ----------------
  logic [IDX_W-1:0] in_cnt_q, in_cnt_d, in_idx;
  logic             dec_stb;

  assign in_idx  = in_sop ? '0 : in_cnt_q;
  assign dec_stb = in_valid && (in_idx == IDX_HEC);

  always_comb begin
    in_cnt_d = in_cnt_q;
    if (in_valid) in_cnt_d = (in_idx == IDX_END) ? IDX_END : in_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_cnt_q <= IDX_END;
    else        in_cnt_q <= in_cnt_d;
  end

  // ---------------- delay line ----------------
  logic [7:0]     pd_q [DLY];
  logic [DLY-1:0] pv_q, ps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= '0;
      ps_q <= '0;
    end else begin
      pv_q <= {pv_q[DLY-2:0], in_valid};
      ps_q <= {ps_q[DLY-2:0], in_valid && in_sop};
    end
  end

  for (genvar g = 0; g < DLY; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) pd_q[0] <= in_data;
    end else begin : g_tail
      always_ff @(posedge clk) pd_q[g] <= pd_q[g-1];
    end
  end

  // ---------------- header check ----------------
  logic [HDR_BITS-1:0] hdr_in, syn_flip, hdr_fix;
  logic                syn_clean, syn_single, do_fix, do_bad;
  logic                is_idle, is_unass;

  assign hdr_in = {pd_q[3], pd_q[2], pd_q[1], pd_q[0], in_data};

  hec_syndrome u_syn (
    .hdr    (hdr_in),
    .clean  (syn_clean),
    .single (syn_single),
    .flip   (syn_flip)
  );

  hec_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_stb (dec_stb),
    .clean   (syn_clean),
    .single  (syn_single),
    .corr_en (corr_en),
    .fix     (do_fix),
    .bad     (do_bad),
    .detect  (in_detect),
    .bad_cnt (bad_cnt)
  );

  assign hdr_fix  = hdr_in ^ (do_fix ? syn_flip : '0);
  // header layout: GFC[39:36] VPI[35:28] VCI[27:12] PT[11:9] CLP[8]
  assign is_idle  = (hdr_fix[HDR_BITS-1:8] == 32'h0000_0001);
  assign is_unass = (hdr_fix[35:12] == '0) && !hdr_fix[8];

  // ---------------- per-cell disposition ----------------
  disp_e               disp_q, disp_d;
  logic [HDR_BITS-1:0] hdr_q;

  always_comb begin
    if (do_bad)                                  disp_d = ima_mode ? DISP_FILL : DISP_DROP;
    else if (drop_idle_en && (is_idle || is_unass)) disp_d = DISP_DROP;
    else                                         disp_d = DISP_PASS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= DISP_PASS;
      hdr_q  <= '0;
    end else if (dec_stb) begin
      disp_q <= disp_d;
      hdr_q  <= hdr_fix;
    end
  end

  // ---------------- output side ----------------
  logic [IDX_W-1:0]    oidx_q, o_idx;
  logic [HDR_BITS-1:0] o_hdr;
  logic [7:0]          o_byte;

  assign o_idx = ps_q[DLY-1] ? '0 : oidx_q;
  assign o_hdr = (disp_q == DISP_FILL) ? FILL_HDR : hdr_q;

  always_comb begin
    o_byte = (disp_q == DISP_FILL) ? IDLE_FILL : pd_q[DLY-1];
    for (int b = 0; b < HDR_BYTES; b++) begin
      if (o_idx == IDX_W'(b)) o_byte = o_hdr[8*(HDR_BYTES-1-b) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oidx_q    <= IDX_END;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      if (pv_q[DLY-1]) oidx_q <= (o_idx == IDX_END) ? IDX_END : o_idx + 1'b1;
      out_valid <= pv_q[DLY-1] && (disp_q != DISP_DROP);
      out_sop   <= ps_q[DLY-1];
      out_data  <= o_byte;
    end
  end

  a_r1_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt_q != IDX_END) |-> in_valid);
  a_r3_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |-> $onehot0(syn_flip));
  a_r2_clean_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && syn_clean) |-> !syn_single);

endmodule

// File: tb/hec_filter_test.sv
module hec_filter_test;

  localparam int CELL = 53;
  localparam int CW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0]    in_data = '0;
  logic          corr_en = 1'b1, ima_mode = 1'b0, drop_idle_en = 1'b0;
  logic          out_valid, out_sop;
  logic [7:0]    out_data;
  logic [CW-1:0] bad_cnt;
  logic          in_detect;

  hec_filter #(.CELL_LEN(CELL), .CNT_W(CW)) uut (
    .clk, .rst_n, .in_valid, .in_sop, .in_data, .corr_en, .ima_mode,
    .drop_idle_en, .out_valid, .out_sop, .out_data, .bad_cnt, .in_detect
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  int         tq[$];
  bit         m_det = 1'b0;
  int         m_cnt = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c;
    c = 8'h00;
    for (int n = 3; n >= 0; n--) begin
      c = c ^ h[8*n +: 8];
      for (int s = 0; s < 8; s++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", {out_sop, out_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({out_sop, out_data} == e, "R2 R3 R8 cell byte", {out_sop, out_data}, e);
      end
      if (out_sop) begin
        if (tq.size() == 0) chk(1'b0, "R1 latency no start", 0, 6);
        else begin
          int t;
          t = tq.pop_front();
          chk(cyc - t == 6, "R1 latency", cyc - t, 6);
        end
      end
    end
  end

  task automatic send(input logic [31:0] h, input logic [7:0] seed,
                      input logic [39:0] flip, input int gap);
    logic [39:0] clean, tx;
    int          n;
    bit          keep, fill;
    clean = {h, ref_hec(h)};
    tx    = clean ^ flip;
    n     = $countones(flip);
    keep  = 1'b0;
    fill  = 1'b0;
    if (n == 0) begin
      m_det = 1'b0; keep = 1'b1;
    end else if (n == 1 && corr_en && !m_det) begin
      m_det = 1'b1; keep = 1'b1;
    end else begin
      m_det = 1'b1;
      if (m_cnt < 7) m_cnt++;
      fill = ima_mode;
    end
    if (keep && drop_idle_en && (h == 32'h1 || (h[27:4] == '0 && !h[0]))) keep = 1'b0;
    for (int k = 0; k < CELL; k++) begin
      if (keep)      exp_q.push_back({k == 0, (k < 5) ? clean[8*(4-k) +: 8] : 8'(seed + k)});
      else if (fill) exp_q.push_back({k == 0, (k < 4) ? 8'(k == 3) : (k == 4) ? 8'h52 : 8'h6A});
    end
    for (int k = 0; k < CELL; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (k == 0);
      in_data  = (k < 5) ? tx[8*(4-k) +: 8] : 8'(seed + k);
      if (k == 0 && (keep || fill)) tq.push_back(cyc);
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
    end
  endtask

  task automatic drain;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(bad_cnt == 0, "R10 bad_cnt", bad_cnt, 0);
    chk(in_detect == 1'b0, "R10 in_detect", in_detect, 0);

    // clean cells, back to back then spaced (R1, R2)
    send(32'h0123_4560, 8'h10, '0, 0);
    send(32'hA5C3_1E72, 8'h40, '0, 3);
    drain();
    chk(in_detect == 1'b0, "R5 clean keeps correction", in_detect, 0);

    // single error in correction: repaired, not counted (R3, R5, R7)
    send(32'h1234_5678, 8'h20, 40'h1 << 20, 2);
    drain();
    chk(in_detect == 1'b1, "R5 error enters detection", in_detect, 1);
    chk(bad_cnt == 0, "R7 repaired not counted", bad_cnt, 0);

    // single error in detection: dropped (R6)
    send(32'h1234_5678, 8'h30, 40'h1 << 33, 2);
    drain();
    chk(bad_cnt == 1, "R6 single in detection dropped", bad_cnt, 1);

    send(32'h0F0F_0F00, 8'h50, '0, 2);
    drain();
    chk(in_detect == 1'b0, "R5 good returns to correction", in_detect, 0);

    // error in the check byte itself (R3)
    send(32'h7654_3210, 8'h60, 40'h1 << 3, 2);
    send(32'h7654_3210, 8'h61, '0, 2);
    drain();
    chk(bad_cnt == 1, "R7 check-byte repair not counted", bad_cnt, 1);

    // correction disabled (R6)
    corr_en = 1'b0;
    send(32'h2222_2220, 8'h70, 40'h1 << 39, 2);
    drain();
    chk(bad_cnt == 2, "R6 correction disabled drops", bad_cnt, 2);

    // double error (R4)
    send(32'h3333_3330, 8'h80, (40'h1 << 39) | (40'h1 << 10), 2);
    drain();
    chk(bad_cnt == 3, "R4 double error dropped", bad_cnt, 3);
    corr_en = 1'b1;
    send(32'h4444_4440, 8'h90, '0, 2);

    // IMA mode filler (R8)
    drain();
    ima_mode = 1'b1;
    send(32'h5555_5550, 8'hA0, (40'h3 << 16), 2);
    send(32'h5555_5550, 8'hA1, 40'h1 << 25, 2);
    send(32'h5555_5550, 8'hA2, '0, 2);
    drain();
    chk(bad_cnt == 5, "R8 filler cells counted", bad_cnt, 5);

    // idle / unassigned filtering (R9)
    drop_idle_en = 1'b1;
    send(32'h0000_0001, 8'hB0, '0, 2);
    send(32'h5000_0000, 8'hB1, '0, 2);
    send(32'h5000_0001, 8'hB2, '0, 2);
    send(32'h0000_0010, 8'hB3, '0, 2);
    drain();
    ima_mode = 1'b0;
    send(32'h0000_0001, 8'hB4, 40'h1 << 12, 2);
    send(32'h0000_0008, 8'hB5, '0, 2);
    drain();
    drop_idle_en = 1'b0;
    send(32'h0000_0001, 8'hC0, '0, 2);
    send(32'h0000_0000, 8'hC1, '0, 2);
    drain();
    chk(bad_cnt == 5, "R9 filtering not counted", bad_cnt, 5);

    // saturation (R7)
    for (int i = 0; i < 4; i++) send(32'h6666_6660, 8'(i), 40'h5 << 30, 1);
    drain();
    chk(bad_cnt == 7, "R7 counter saturates", bad_cnt, 7);
    chk(in_detect == 1'b1, "R5 still in detection", in_detect, 1);

    drain();
    chk(exp_q.size() == 0, "R1 all expected bytes seen", exp_q.size(), 0);
    chk(int'(bad_cnt) == m_cnt, "R7 model count", bad_cnt, m_cnt);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule